// File: doc/BRIEF.md
# Paged Nonvolatile Write-Load Controller

This block is a cycle-based model of the write side of a byte-wide, page-organised nonvolatile memory. The host drives active-low write strobe, chip select and output enable lines, an address and a data byte. A write pulse is the interval in which strobe and chip select are both low. Each qualified pulse places one byte in a page buffer and sets that byte's bit in a per-byte mask. The first byte of a load fixes the page. Later bytes for the same page may arrive in any order, and a byte that is written twice keeps its newer value.

A load ends when no byte for the page has been accepted for a programmable number of cycles. The block then stays busy for a fixed programming time. At the end of that time it writes only the masked bytes into a behavioural storage array, and every other byte of the page keeps its old value. A synchronous read path returns array contents one cycle after a read request. The block also reports the most recently accepted address and data byte, and a sticky flag that is set when a byte names a different page from the one being loaded.

All timings are parameters counted in clock cycles: the minimum pulse width, the byte-load window and the programming time.

Top module: `paged_nv_writer`

## Requirements
- R1: After a synchronous active-low reset, busy and page_err are 0 and last_addr and last_data are 0. Any page load still open is discarded, so nothing from it is programmed. Array contents are kept through reset.
- R2: A write pulse is the run of cycles in which we_n and ce_n are both sampled low. The address is taken in the first cycle of the pulse. The data byte is taken in the last cycle of the pulse.
- R3: A pulse shorter than MIN_PW cycles (default 3) is ignored. A pulse of exactly MIN_PW cycles is accepted.
- R4: A pulse in which oe_n is sampled low in any cycle is ignored. Holding we_n low while ce_n stays high writes nothing.
- R5: The low OFF_W address bits (7, giving 128 bytes) select the byte within the page, and the upper PAGE_W bits select the page. Bytes of one load may come in any order. A byte written twice in one load is programmed with its later value.
- R6: When programming ends, only the bytes loaded in that load change in the array. Every other byte of the page, and of the array, keeps its value.
- R7: busy rises BLC_CYC+1 cycles after the cycle in which the last accepted pulse ended. busy then stays high for exactly TWC_CYC cycles, and the array shows the new bytes once busy has fallen.
- R8: During a load, a pulse whose page bits differ from the locked page is dropped. It sets page_err, which stays at 1 until reset.
- R9: Pulses that complete while busy is high change neither the array nor last_addr and last_data, and they start no new programming period.
- R10: last_addr and last_data show the address and data of the most recently accepted byte.
- R11: With ce_n and oe_n low and we_n high, rd_data shows the array byte at addr one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Write strobe, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low; inhibits writes when low |
| addr | input | PAGE_W+OFF_W (10) | Byte address: page bits above offset bits |
| din | input | DATA_W (8) | Write data byte |
| rd_data | output | DATA_W (8) | Registered read data |
| busy | output | 1 | High during the internal programming period |
| page_err | output | 1 | Sticky page-mismatch flag |
| last_addr | output | PAGE_W+OFF_W (10) | Address of the last accepted byte |
| last_data | output | DATA_W (8) | Data of the last accepted byte |

## Verification
The assertions check several properties on every cycle:
- every accepted pulse met the width rule and had output enable high throughout;
- page_err is sticky and follows a mismatched byte;
- the load-window and programming counters stay within their limits;
- the mask and the last-byte outputs hold still while busy;
- busy falls right after the commit.

Some behaviour shows only at the ports, so the bench scenarios cover it:
- which bytes the array actually holds after a commit, including untouched neighbours and rewritten bytes;
- the address-first and data-last capture;
- the exact cycle in which busy rises and how long it lasts;
- the loss of an open load at reset.

// File: rtl/nvw_pkg.sv
// Shared types for the paged write-load controller.
package nvw_pkg;
    // Phases of a page load: waiting for a first byte, collecting bytes, programming
    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_COLLECT = 2'd1,
        LD_PROGRAM = 2'd2
    } ld_state_t;
endpackage

// File: rtl/nvw_strobe.sv
// Write-pulse qualifier.
// Turns the asynchronous-style strobe/select pair into one-cycle byte events.
// Address is sampled in the first cycle of a pulse, data in the last one.
// A pulse is dropped if it was shorter than MIN_PW cycles or if output
// enable was seen low in any of its cycles.
// Assumes all inputs are already synchronous to clk.
module nvw_strobe #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int MIN_PW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              evt_o,
    output logic [ADDR_W-1:0] evt_addr_o,
    output logic [DATA_W-1:0] evt_data_o
);
    localparam int CW = $clog2(MIN_PW + 1);

    logic              pulse;
    logic              pulse_q;
    logic [CW-1:0]     width_q;
    logic              oe_ok_q;
    logic [ADDR_W-1:0] cap_addr_q;
    logic [DATA_W-1:0] cap_data_q;

    assign pulse = ~we_n & ~ce_n;

    // Track the pulse, its width and its captures, and emit the event at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q    <= 1'b0;
            width_q    <= '0;
            oe_ok_q    <= 1'b0;
            cap_addr_q <= '0;
            cap_data_q <= '0;
            evt_o      <= 1'b0;
            evt_addr_o <= '0;
            evt_data_o <= '0;
        end else begin
            pulse_q <= pulse;
            evt_o   <= 1'b0;
            if (pulse && !pulse_q) begin
                cap_addr_q <= addr;
                cap_data_q <= din;
                width_q    <= CW'(1);
                oe_ok_q    <= oe_n;
            end else if (pulse) begin
                cap_data_q <= din;
                if (width_q < CW'(MIN_PW)) width_q <= width_q + CW'(1);
                oe_ok_q <= oe_ok_q & oe_n;
            end else if (pulse_q) begin
                evt_o      <= oe_ok_q && (width_q >= CW'(MIN_PW));
                evt_addr_o <= cap_addr_q;
                evt_data_o <= cap_data_q;
            end
        end
    end

    // R3
    pw_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ($past(width_q) >= CW'(MIN_PW)));
    // R4
    oe_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(oe_ok_q));
    // R2
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);
endmodule

// File: rtl/nvw_page_buf.sv
// Page load sequencer and buffer.
// The first accepted byte locks the page. Later bytes of that page fill the
// buffer and set mask bits. The load closes after BLC_CYC cycles without an
// accepted byte. The block then is busy for TWC_CYC cycles and raises
// commit in its last cycle.
// Assumes evt is a single-cycle pulse from the strobe qualifier.
module nvw_page_buf
    import nvw_pkg::*;
#(
    parameter int OFF_W   = 7,
    parameter int PAGE_W  = 3,
    parameter int DATA_W  = 8,
    parameter int BLC_CYC = 40,
    parameter int TWC_CYC = 100
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                evt,
    input  logic [PAGE_W+OFF_W-1:0]             evt_addr,
    input  logic [DATA_W-1:0]                   evt_data,
    output logic                                busy,
    output logic                                err,
    output logic                                commit,
    output logic [PAGE_W-1:0]                   page_o,
    output logic [(1<<OFF_W)-1:0]               mask_o,
    output logic [(1<<OFF_W)-1:0][DATA_W-1:0]   buf_o,
    output logic [PAGE_W+OFF_W-1:0]             last_addr,
    output logic [DATA_W-1:0]                   last_data
);
    localparam int ADDR_W     = PAGE_W + OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int TW         = $clog2(BLC_CYC + 1);
    localparam int PW         = $clog2(TWC_CYC + 1);

    ld_state_t                           st_q;
    logic [PAGE_W-1:0]                   page_q;
    logic [PAGE_BYTES-1:0]               mask_q;
    logic [PAGE_BYTES-1:0][DATA_W-1:0]   buf_q;
    logic [TW-1:0]                       win_q;
    logic [PW-1:0]                       pcnt_q;
    logic [PAGE_W-1:0]                   evt_page;
    logic [OFF_W-1:0]                    evt_off;
    logic                                page_hit;
    logic                                accept;

    assign evt_page = evt_addr[ADDR_W-1:OFF_W];
    assign evt_off  = evt_addr[OFF_W-1:0];
    assign page_hit = (evt_page == page_q);
    assign accept   = evt && ((st_q == LD_IDLE) || ((st_q == LD_COLLECT) && page_hit));
    assign busy     = (st_q == LD_PROGRAM);
    assign commit   = busy && (pcnt_q == PW'(TWC_CYC - 1));
    assign page_o   = page_q;
    assign mask_o   = mask_q;
    assign buf_o    = buf_q;

    // Sequence the load window, the programming period, the mask and the flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= LD_IDLE;
            page_q    <= '0;
            mask_q    <= '0;
            win_q     <= '0;
            pcnt_q    <= '0;
            err       <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            if (accept) begin
                mask_q[evt_off] <= 1'b1;
                last_addr       <= evt_addr;
                last_data       <= evt_data;
            end
            case (st_q)
                LD_IDLE: begin
                    if (evt) begin
                        page_q <= evt_page;
                        win_q  <= '0;
                        st_q   <= LD_COLLECT;
                    end
                end
                LD_COLLECT: begin
                    if (evt && !page_hit) err <= 1'b1;
                    if (accept) begin
                        win_q <= '0;
                    end else if (win_q == TW'(BLC_CYC - 1)) begin
                        pcnt_q <= '0;
                        st_q   <= LD_PROGRAM;
                    end else begin
                        win_q <= win_q + TW'(1);
                    end
                end
                LD_PROGRAM: begin
                    if (commit) begin
                        mask_q <= '0;
                        st_q   <= LD_IDLE;
                    end else begin
                        pcnt_q <= pcnt_q + PW'(1);
                    end
                end
                default: st_q <= LD_IDLE;
            endcase
        end
    end

    // Store the data byte of every accepted write in its page slot
    always_ff @(posedge clk) begin
        if (accept) buf_q[evt_off] <= evt_data;
    end

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R8
    err_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LD_COLLECT && evt && !page_hit) |=> err);
    // R7
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LD_COLLECT) |-> (win_q < TW'(BLC_CYC)));
    // R7
    prog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pcnt_q < PW'(TWC_CYC)));
    // R9
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_addr) && $stable(last_data)));
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> $stable(mask_o));
endmodule

// File: rtl/nvw_array.sv
// Behavioural byte array with page commit and a registered read port.
// On commit, every masked byte of the buffer is written into the selected page.
// Contents are never reset.
module nvw_array #(
    parameter int OFF_W  = 7,
    parameter int PAGE_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                commit,
    input  logic [PAGE_W-1:0]                   page,
    input  logic [(1<<OFF_W)-1:0]               mask,
    input  logic [(1<<OFF_W)-1:0][DATA_W-1:0]   buf_data,
    input  logic                                rd_en,
    input  logic [PAGE_W+OFF_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]                   rd_data
);
    localparam int ADDR_W     = PAGE_W + OFF_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << OFF_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Program the marked bytes of the committed page
    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (commit && mask[i]) mem[{page, OFF_W'(i)}] <= buf_data[i];
        end
    end

    // Return the addressed byte one cycle after a read request
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/paged_nv_writer.sv
// Top level of the paged write-load controller.
// Chains the pulse qualifier, the page sequencer and the storage array.
// A read request is ce_n and oe_n low with we_n high.
module paged_nv_writer #(
    parameter int OFF_W   = 7,
    parameter int PAGE_W  = 3,
    parameter int DATA_W  = 8,
    parameter int MIN_PW  = 3,
    parameter int BLC_CYC = 40,
    parameter int TWC_CYC = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_n,
    input  logic                     ce_n,
    input  logic                     oe_n,
    input  logic [PAGE_W+OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0]        din,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     busy,
    output logic                     page_err,
    output logic [PAGE_W+OFF_W-1:0]  last_addr,
    output logic [DATA_W-1:0]        last_data
);
    localparam int ADDR_W     = PAGE_W + OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;

    logic                                evt;
    logic [ADDR_W-1:0]                   evt_addr;
    logic [DATA_W-1:0]                   evt_data;
    logic                                commit;
    logic [PAGE_W-1:0]                   cm_page;
    logic [PAGE_BYTES-1:0]               cm_mask;
    logic [PAGE_BYTES-1:0][DATA_W-1:0]   cm_buf;
    logic                                rd_en;

    assign rd_en = ~ce_n & ~oe_n & we_n;

    nvw_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PW(MIN_PW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
        .addr(addr), .din(din),
        .evt_o(evt), .evt_addr_o(evt_addr), .evt_data_o(evt_data)
    );

    nvw_page_buf #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                   .BLC_CYC(BLC_CYC), .TWC_CYC(TWC_CYC)) u_page (
        .clk(clk), .rst_n(rst_n), .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data),
        .busy(busy), .err(page_err), .commit(commit), .page_o(cm_page),
        .mask_o(cm_mask), .buf_o(cm_buf), .last_addr(last_addr), .last_data(last_data)
    );

    nvw_array #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page(cm_page), .mask(cm_mask),
        .buf_data(cm_buf), .rd_en(rd_en), .rd_addr(addr), .rd_data(rd_data)
    );

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
    // R6
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);
endmodule

// File: tb/sim_paged_nv_writer.sv
`timescale 1ns/1ps
module sim_paged_nv_writer;
    localparam int OFF_W = 7, PAGE_W = 3, DATA_W = 8;
    localparam int MIN_PW = 3, BLC = 40, TWC = 100;
    localparam int DEPTH = 1 << (OFF_W + PAGE_W);

    logic clk = 1'b0, rst_n = 1'b0, we_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1;
    logic [9:0] addr_i = '0;
    logic [7:0] din_i = '0;
    logic [7:0] rd_data, last_data;
    logic [9:0] last_addr;
    logic busy, page_err;
    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] model [DEPTH];

    always #2.5 clk = ~clk;

    paged_nv_writer #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .MIN_PW(MIN_PW),
                      .BLC_CYC(BLC), .TWC_CYC(TWC)) u0 (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
        .addr(addr_i), .din(din_i), .rd_data(rd_data), .busy(busy),
        .page_err(page_err), .last_addr(last_addr), .last_data(last_data)
    );

    function automatic logic [7:0] fill_val(int a);
        return 8'((a * 7) + (a / 128) * 29 + 3);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one write pulse of w cycles; oe_v is the output enable level held during it
    task automatic wr(input int a, input int d, input int w, input bit oe_v);
        @(negedge clk);
        addr_i = 10'(a); din_i = 8'(d); oe_n = oe_v; ce_n = 1'b0; we_n = 1'b0;
        repeat (w) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_chk(input int a, input string tag);
        @(negedge clk);
        addr_i = 10'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        chk(tag, 32'(rd_data), 32'(model[a]));
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic settle();
        repeat (BLC + TWC + 10) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        int p, o, d, cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 page_err", 32'(page_err), 0);
        chk("R1 last_addr", 32'(last_addr), 0);
        chk("R1 last_data", 32'(last_data), 0);

        // R5 full 128-byte page loads fill the whole array
        for (int pg = 0; pg < 8; pg++) begin
            for (int of = 0; of < 128; of++) begin
                wr(pg * 128 + of, fill_val(pg * 128 + of), 4, 1'b1);
                model[pg * 128 + of] = fill_val(pg * 128 + of);
            end
            settle();
        end
        rd_chk(0, "R5 first byte");
        rd_chk(127, "R5 page end");
        rd_chk(128, "R5 next page");
        rd_chk(1023, "R11 last byte");

        // R7 busy timing and length, R6 neighbours, R10 last byte
        wr(261, 8'h5A, 4, 1'b1);
        repeat (BLC + 1) @(negedge clk);
        chk("R7 busy before window close", 32'(busy), 0);
        @(negedge clk);
        chk("R7 busy at window close", 32'(busy), 1);
        chk("R10 last_addr", 32'(last_addr), 261);
        chk("R10 last_data", 32'(last_data), 32'h5A);
        n = 1;
        for (int k = 0; k < 2 * TWC && busy; k++) begin
            @(negedge clk);
            if (busy) n++;
        end
        chk("R7 busy length", 32'(n), 32'(TWC));
        model[261] = 8'h5A;
        rd_chk(261, "R7 committed byte");
        rd_chk(260, "R6 lower neighbour");
        rd_chk(262, "R6 upper neighbour");

        // R2 address at pulse start, data at pulse end, later-falling strobe
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr_i = 10'(404);
        @(negedge clk); we_n = 1'b0; addr_i = 10'(394); din_i = 8'h11;
        @(negedge clk); addr_i = 10'(404); din_i = 8'h22;
        @(negedge clk); din_i = 8'hC3;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1;
        settle();
        model[394] = 8'hC3;
        rd_chk(394, "R2 first-cycle address, last-cycle data");
        rd_chk(404, "R2 late address unused");

        // R3 short pulse ignored
        wr(300, 8'h99, MIN_PW - 1, 1'b1);
        repeat (BLC + 3) @(negedge clk);
        chk("R3 short pulse starts no programming", 32'(busy), 0);
        settle();
        rd_chk(300, "R3 short pulse ignored");

        // R4 output enable low during the pulse; we_n low with ce_n high
        wr(301, 8'h98, 4, 1'b0);
        @(negedge clk); addr_i = 10'(302); din_i = 8'h97; ce_n = 1'b1; we_n = 1'b0;
        repeat (5) @(negedge clk);
        we_n = 1'b1;
        repeat (BLC + 3) @(negedge clk);
        chk("R4 inhibited pulses start no programming", 32'(busy), 0);
        rd_chk(301, "R4 oe low ignored");
        rd_chk(302, "R4 ce high ignored");

        // R5 any order and rewrite within one load
        wr(4 * 128 + 100, 8'h01, 3, 1'b1);
        wr(4 * 128 + 3, 8'h02, 3, 1'b1);
        wr(4 * 128 + 100, 8'h03, 3, 1'b1);
        wr(4 * 128 + 64, 8'h04, 3, 1'b1);
        settle();
        model[612] = 8'h03; model[515] = 8'h02; model[576] = 8'h04;
        rd_chk(612, "R5 rewrite keeps later value");
        rd_chk(515, "R5 out-of-order byte");
        rd_chk(576, "R5 out-of-order byte");
        rd_chk(577, "R6 untouched byte");

        // R8 page mismatch dropped, sticky error
        wr(5 * 128 + 1, 8'hA1, 4, 1'b1);
        wr(6 * 128 + 2, 8'hB2, 4, 1'b1);
        repeat (3) @(negedge clk);
        chk("R8 error raised", 32'(page_err), 1);
        chk("R8 dropped byte not recorded", 32'(last_addr), 32'(5 * 128 + 1));
        settle();
        model[641] = 8'hA1;
        rd_chk(641, "R8 locked page byte");
        rd_chk(770, "R8 mismatched byte dropped");
        chk("R8 error sticky", 32'(page_err), 1);

        // R9 writes while busy ignored
        wr(128 + 9, 8'h77, 4, 1'b1);
        repeat (BLC + 5) @(negedge clk);
        chk("R9 busy", 32'(busy), 1);
        wr(128 + 10, 8'h88, 4, 1'b1);
        repeat (3) @(negedge clk);
        chk("R9 last_addr held", 32'(last_addr), 32'(128 + 9));
        settle();
        chk("R9 no second programming", 32'(busy), 0);
        model[137] = 8'h77;
        rd_chk(137, "R9 first byte programmed");
        rd_chk(138, "R9 busy write ignored");

        // R1 reset during load discards it, keeps array, clears error
        wr(7 * 128, 8'hEE, 4, 1'b1);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 error cleared", 32'(page_err), 0);
        settle();
        chk("R1 no programming after reset", 32'(busy), 0);
        rd_chk(896, "R1 open load discarded");
        rd_chk(641, "R1 array kept");

        // R6 random partial loads checked over whole pages
        d = int'($urandom(32'd4242));
        for (int r = 0; r < 6; r++) begin
            p = int'($urandom % 8);
            cnt = 1 + int'($urandom % 12);
            for (int k = 0; k < cnt; k++) begin
                o = int'($urandom % 128);
                d = int'($urandom % 256);
                wr(p * 128 + o, d, 3 + int'($urandom % 3), 1'b1);
                model[p * 128 + o] = 8'(d);
            end
            settle();
            for (int of = 0; of < 128; of++) rd_chk(p * 128 + of, "R6 random page");
        end

        summary();
        $finish;
    end
endmodule